// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the register front end of an interrupt routing controller. Software reaches all of its state through two bus words. The first is a select word, which picks a target. The second is a data window, which reads or writes the picked target. There are three kinds of target: a read-only version word, a 4-bit identification word, and one 32-bit half of a 64-bit routing entry. There is one routing entry per interrupt pin, 24 by default.

The pin logic next to this block receives every routing entry on a flat output bus. It also receives a one-cycle service strobe per pin. The strobe fires after software rewrites an entry whose request latch is set, so that pin is evaluated again for delivery. The pin logic drives three inputs back into the block:

- a remote-pending set pulse, for when a level-triggered delivery is accepted;
- a request-latch set pulse per pin;
- a request-latch clear pulse per pin.

The bus is a plain single-cycle slave with no back-pressure. A write takes effect on the clock edge where `bus_we` is high. Read data depends combinationally on the address and on the current state. Reads have no side effects.

Top module: `ioreg_window`

## Requirements
- R1: After reset, the select word and the ID are 0. Every routing entry is 64'h0000_0000_0001_0000, with only the mask bit (bit 16) set. `svc_o` is 0 and every request latch is clear.
- R2: The select word is at byte offset 0x00 and the window at 0x10. Only `bus_addr[7:0]` is decoded, so offset 0x100 aliases 0x00. A select write stores `bus_wdata[31:0]`. A select read returns the stored word zero-extended to 64 bits.
- R3: A write is accepted only when `bus_size` is 4 or 8 (bytes). Only `bus_wdata[31:0]` is used. A write of any other size has no effect.
- R4: Select value 0x01 is the version word. It reads NUM_PINS-1 in bits 23:16 and VERSION_CODE in bits 7:0, with all other bits zero. Window writes to it are ignored.
- R5: Select value 0x00 is the ID word. A window write stores `bus_wdata[27:24]`, and a read returns the ID in bits 27:24 with all other bits zero. Select value 0x02 reads the same ID, and window writes to it are ignored.
- R6: A select value s of 0x10 or above addresses entry (s-0x10)>>1. An odd s reaches bits 63:32 of that entry and an even s reaches bits 31:0. Entry i appears on `route_o[i*64 +: 64]`.
- R7: A window write to the low half of an entry always leaves that entry's remote-pending bit (bit 14) at 0, whatever the written data. A write to the high half leaves bit 14 unchanged.
- R8: A pulse on `rp_set[i]` sets bit 14 of entry i. If a low-half write to the same entry lands in the same cycle, the write's clear wins.
- R9: A window write is discarded when the select value is 0x03 to 0x0F, or when it maps to an entry index of NUM_PINS or more. A window read of such a select returns 0.
- R10: `svc_o[i]` is high for exactly the one cycle after an accepted window write to either half of entry i, and only if request latch i was set before that write. `req_set[i]` sets the latch and `req_clr[i]` clears it; set wins when both are high.
- R11: Offsets other than 0x00 and 0x10 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address; low 8 bits decoded |
| bus_we | input | 1 | Write enable |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data; low 32 bits used |
| bus_rdata | output | 64 | Read data, zero-extended 32-bit value |
| rp_set | input | NUM_PINS | Per-pin remote-pending set pulse |
| req_set | input | NUM_PINS | Per-pin request latch set pulse |
| req_clr | input | NUM_PINS | Per-pin request latch clear pulse |
| route_o | output | NUM_PINS*64 | All routing entries, entry i at bits i*64+63:i*64 |
| svc_o | output | NUM_PINS | Per-pin service strobe |

## Verification
The window is exercised with each select class in turn: the version, ID and arbitration selects, the even and odd selects of the first, middle and last entries, the gap selects 0x03 to 0x0F, and a select one past the table. This shows whether the index arithmetic and the half selection are right, and whether writes to read-only or out-of-range targets leak into any entry. Low-half writes are made with bit 14 set in the data, and in the same cycle as an `rp_set` pulse. These separate a write that clears the remote-pending bit from one that merely copies the data. Service strobes are checked with the request latch set, cleared, and for a neighbouring pin, which exposes a strobe on the wrong pin or one that ignores the latch.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
  localparam int ENTRY_W = 64;
  localparam int HALF_W  = 32;
  localparam logic [7:0]  OFF_SEL = 8'h00;
  localparam logic [7:0]  OFF_WIN = 8'h10;
  localparam logic [31:0] SEL_ID  = 32'h0;
  localparam logic [31:0] SEL_VER = 32'h1;
  localparam logic [31:0] SEL_ARB = 32'h2;
  localparam logic [31:0] SEL_TBL = 32'h10;
  localparam int BIT_RPEND = 14;
  localparam int BIT_MASK  = 16;

  typedef enum logic [2:0] {
    TGT_ID, TGT_VER, TGT_ARB, TGT_LO, TGT_HI, TGT_NONE
  } tgt_e;

  typedef struct packed {
    tgt_e        tgt;
    logic [31:0] idx;
  } sel_dec_t;

  // Map a select word onto a window target and a table index.
  function automatic sel_dec_t decode_sel(logic [31:0] sel, logic [31:0] npins);
    sel_dec_t d;
    logic [31:0] rel;
    d.tgt = TGT_NONE;
    d.idx = '0;
    rel   = sel - SEL_TBL;
    if (sel == SEL_ID)       d.tgt = TGT_ID;
    else if (sel == SEL_VER) d.tgt = TGT_VER;
    else if (sel == SEL_ARB) d.tgt = TGT_ARB;
    else if (sel >= SEL_TBL) begin
      d.idx = rel >> 1;
      if (d.idx < npins) d.tgt = sel[0] ? TGT_HI : TGT_LO;
    end
    return d;
  endfunction
endpackage

// File: rtl/ioreg_bus_decode.sv
module ioreg_bus_decode
  import ioreg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [3:0]        bus_size,
  output logic              sel_we,
  output logic              win_we,
  output logic              rd_sel,
  output logic              rd_win
);
  logic [7:0] off;
  logic       size_ok;
  logic       unused_hi;

  assign off       = bus_addr[7:0];
  assign unused_hi = ^bus_addr[ADDR_W-1:8];

  // Only word and double-word writes are accepted.
  assign size_ok = (bus_size == 4'd4) || (bus_size == 4'd8);

  assign rd_sel = (off == OFF_SEL);
  assign rd_win = (off == OFF_WIN);
  assign sel_we = bus_we && size_ok && rd_sel;
  assign win_we = bus_we && size_ok && rd_win;
endmodule

// File: rtl/ioreg_route_table.sv
module ioreg_route_table
  import ioreg_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_lo,
  input  logic                         wr_hi,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [HALF_W-1:0]            wr_data,
  input  logic [NUM_PINS-1:0]          rp_set,
  input  logic [NUM_PINS-1:0]          req_set,
  input  logic [NUM_PINS-1:0]          req_clr,
  output logic [NUM_PINS*ENTRY_W-1:0]  route_o,
  output logic [NUM_PINS-1:0]          svc_o
);
  localparam logic [ENTRY_W-1:0] ENTRY_RST = ENTRY_W'(1) << BIT_MASK;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic [ENTRY_W-1:0] ent_q;
    logic               req_q;
    logic               hit;

    assign hit = (wr_idx == IDX_W'(i));
    assign route_o[i*ENTRY_W +: ENTRY_W] = ent_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= ENTRY_RST;
      end else begin
        if (rp_set[i]) ent_q[BIT_RPEND] <= 1'b1;
        // Later assignment wins: software clear beats a same-cycle set.
        if (hit && wr_lo)
          ent_q[HALF_W-1:0] <= {wr_data[HALF_W-1:BIT_RPEND+1], 1'b0,
                                wr_data[BIT_RPEND-1:0]};
        if (hit && wr_hi)
          ent_q[ENTRY_W-1:HALF_W] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q    <= 1'b0;
        svc_o[i] <= 1'b0;
      end else begin
        req_q    <= (req_q & ~req_clr[i]) | req_set[i];
        svc_o[i] <= hit && (wr_lo || wr_hi) && req_q;
      end
    end
  end
endmodule

// File: rtl/ioreg_window.sv
module ioreg_window
  import ioreg_pkg::*;
#(
  parameter int         ADDR_W       = 16,
  parameter int         NUM_PINS     = 24,
  parameter logic [7:0] VERSION_CODE = 8'h11
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [3:0]                   bus_size,
  input  logic [63:0]                  bus_wdata,
  output logic [63:0]                  bus_rdata,
  input  logic [NUM_PINS-1:0]          rp_set,
  input  logic [NUM_PINS-1:0]          req_set,
  input  logic [NUM_PINS-1:0]          req_clr,
  output logic [NUM_PINS*ENTRY_W-1:0]  route_o,
  output logic [NUM_PINS-1:0]          svc_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [HALF_W-1:0] VER_WORD =
    {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_CODE};

  logic [31:0]       sel_q;
  logic [3:0]        id_q;
  logic              sel_we, win_we, rd_sel, rd_win;
  sel_dec_t          dec;
  logic [IDX_W-1:0]  idx;
  logic [HALF_W-1:0] win_rd;
  logic              unused_bits;

  ioreg_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_size (bus_size),
    .sel_we   (sel_we),
    .win_we   (win_we),
    .rd_sel   (rd_sel),
    .rd_win   (rd_win)
  );

  assign dec         = decode_sel(sel_q, 32'(NUM_PINS));
  assign idx         = dec.idx[IDX_W-1:0];
  assign unused_bits = ^{bus_wdata[63:32], dec.idx[31:IDX_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_we) sel_q <= bus_wdata[31:0];
      if (win_we && dec.tgt == TGT_ID) id_q <= bus_wdata[27:24];
    end
  end

  ioreg_route_table #(.NUM_PINS(NUM_PINS)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (win_we && dec.tgt == TGT_LO),
    .wr_hi   (win_we && dec.tgt == TGT_HI),
    .wr_idx  (idx),
    .wr_data (bus_wdata[HALF_W-1:0]),
    .rp_set  (rp_set),
    .req_set (req_set),
    .req_clr (req_clr),
    .route_o (route_o),
    .svc_o   (svc_o)
  );

  always_comb begin
    unique case (dec.tgt)
      TGT_ID, TGT_ARB: win_rd = {4'h0, id_q, 24'h0};
      TGT_VER:         win_rd = VER_WORD;
      TGT_LO:          win_rd = route_o[int'(idx)*ENTRY_W +: HALF_W];
      TGT_HI:          win_rd = route_o[int'(idx)*ENTRY_W + HALF_W +: HALF_W];
      default:         win_rd = '0;
    endcase
  end

  always_comb begin
    if (rd_sel)      bus_rdata = {32'h0, sel_q};
    else if (rd_win) bus_rdata = {32'h0, win_rd};
    else             bus_rdata = '0;
  end
endmodule

// File: rtl/ioreg_window_chk.sv
module ioreg_window_chk
  import ioreg_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_PINS = 24
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [3:0]                  bus_size,
  input logic [63:0]                 bus_rdata,
  input logic [31:0]                 sel_q,
  input logic [NUM_PINS*ENTRY_W-1:0] route_o,
  input logic [NUM_PINS-1:0]         svc_o
);
  logic     size_ok, win_wr, lw_q;
  sel_dec_t dc;
  logic [31:0] lw_idx_q;

  assign size_ok = (bus_size == 4'd4) || (bus_size == 4'd8);
  assign win_wr  = bus_we && size_ok && (bus_addr[7:0] == OFF_WIN);
  assign dc      = decode_sel(sel_q, 32'(NUM_PINS));

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_q     <= 1'b0;
      lw_idx_q <= '0;
    end else begin
      lw_q     <= win_wr && (dc.tgt == TGT_LO);
      lw_idx_q <= dc.idx;
    end
  end

  // R10: at most one service strobe at a time
  a_r10_svc_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(svc_o));

  // R10: a strobe only follows an accepted window write
  a_r10_svc_after_write: assert property (@(posedge clk) disable iff (rst)
    (|svc_o) |-> $past(win_wr));

  // R3: a write of a bad size leaves the select word alone
  a_r3_bad_size_keeps_sel: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !size_ok) |=> $stable(sel_q));

  // R11: unknown offsets read zero
  a_r11_unknown_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[7:0] != OFF_SEL && bus_addr[7:0] != OFF_WIN) |-> (bus_rdata == 64'h0));

  // R5: the ID word carries nothing outside bits 27:24
  a_r5_id_bits_only: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[7:0] == OFF_WIN && sel_q == SEL_ID) |->
      (bus_rdata[63:28] == '0 && bus_rdata[23:0] == '0));

  // R7: after a low-half write the remote-pending bit is clear
  a_r7_low_write_clears: assert property (@(posedge clk) disable iff (rst)
    lw_q |-> (route_o[int'(lw_idx_q)*ENTRY_W + BIT_RPEND] == 1'b0));
endmodule

bind ioreg_window ioreg_window_chk #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_size  (bus_size),
  .bus_rdata (bus_rdata),
  .sel_q     (sel_q),
  .route_o   (route_o),
  .svc_o     (svc_o)
);

// File: tb/sim_ioreg_window.sv
module sim_ioreg_window;
  localparam int NP = 24;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [3:0]    bus_size = 4'd4;
  logic [63:0]   bus_wdata = '0;
  logic [63:0]   bus_rdata;
  logic [NP-1:0] rp_set = '0, req_set = '0, req_clr = '0;
  logic [NP*64-1:0] route_o;
  logic [NP-1:0] svc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ioreg_window #(.ADDR_W(AW), .NUM_PINS(NP), .VERSION_CODE(8'h11)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rp_set(rp_set), .req_set(req_set), .req_clr(req_clr),
    .route_o(route_o), .svc_o(svc_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [AW-1:0] a, logic [63:0] d, logic [3:0] sz);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_size = 4'd4;
  endtask

  task automatic bread(logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic setsel(logic [31:0] s);
    bwrite(16'h0000, {32'hdead_beef, s}, 4'd4);
  endtask

  function automatic logic [63:0] ent(int i);
    return route_o[i*64 +: 64];
  endfunction

  task automatic t_reset;
    logic [63:0] r;
    bread(16'h0000, r);  check("R1 sel", r, 64'h0);
    bread(16'h0010, r);  check("R1 id", r, 64'h0);
    for (int i = 0; i < NP; i++)
      if (ent(i) !== 64'h1_0000) check("R1 entry", ent(i), 64'h1_0000);
    check("R1 all entries", {63'h0, route_o == {NP{64'h1_0000}}}, 64'h1);
    check("R1 svc", 64'(svc_o), 64'h0);
  endtask

  task automatic t_select;
    logic [63:0] r;
    bwrite(16'h0000, 64'h1234_5678, 4'd4);
    bread(16'h0000, r);  check("R2 sel readback", r, 64'h1234_5678);
    bwrite(16'h0100, 64'h22, 4'd4);
    bread(16'h0000, r);  check("R2 alias", r, 64'h22);
  endtask

  task automatic t_size;
    logic [63:0] r;
    bwrite(16'h0000, 64'h55, 4'd2);
    bread(16'h0000, r);  check("R3 size2 ignored", r, 64'h22);
    bwrite(16'h0000, 64'h55, 4'd1);
    bread(16'h0000, r);  check("R3 size1 ignored", r, 64'h22);
    bwrite(16'h0000, 64'hffff_0000_0000_0033, 4'd8);
    bread(16'h0000, r);  check("R3 size8 low word", r, 64'h33);
  endtask

  task automatic t_version;
    logic [63:0] r;
    setsel(32'h1);
    bread(16'h0010, r);  check("R4 version", r, 64'h0017_0011);
    bwrite(16'h0010, 64'hffff_ffff, 4'd4);
    bread(16'h0010, r);  check("R4 write ignored", r, 64'h0017_0011);
  endtask

  task automatic t_id;
    logic [63:0] r;
    setsel(32'h0);
    bwrite(16'h0010, 64'ha5ff_ffff, 4'd4);
    bread(16'h0010, r);  check("R5 id", r, 64'h0500_0000);
    setsel(32'h2);
    bread(16'h0010, r);  check("R5 arb reads id", r, 64'h0500_0000);
    bwrite(16'h0010, 64'h0f00_0000, 4'd4);
    setsel(32'h0);
    bread(16'h0010, r);  check("R5 arb write ignored", r, 64'h0500_0000);
  endtask

  task automatic t_entry;
    logic [63:0] r;
    setsel(32'h16);
    bwrite(16'h0010, 64'h0000_a0b1, 4'd4);
    bread(16'h0010, r);  check("R6 entry3 lo read", r, 64'h0000_a0b1);
    setsel(32'h17);
    bwrite(16'h0010, 64'hc300_0000, 4'd4);
    bread(16'h0010, r);  check("R6 entry3 hi read", r, 64'hc300_0000);
    check("R6 entry3 export", ent(3), 64'hc300_0000_0000_a0b1);
    setsel(32'h3f);
    bwrite(16'h0010, 64'h0100_0000, 4'd4);
    setsel(32'h3e);
    bwrite(16'h0010, 64'h0000_00fe, 4'd4);
    check("R6 entry23 export", ent(23), 64'h0100_0000_0000_00fe);
    check("R6 entry0 untouched", ent(0), 64'h1_0000);
  endtask

  task automatic t_rpend;
    logic [63:0] r;
    @(negedge clk); rp_set = NP'(1) << 5;
    @(negedge clk); rp_set = '0;
    check("R8 rp_set sets bit14", ent(5), 64'h1_4000);
    setsel(32'h1b);
    bwrite(16'h0010, 64'h7700_0000, 4'd4);
    check("R7 hi write keeps bit14", ent(5), 64'h7700_0000_0001_4000);
    setsel(32'h1a);
    bwrite(16'h0010, 64'h0000_4020, 4'd4);
    bread(16'h0010, r);  check("R7 lo write clears bit14", r, 64'h0000_0020);
    @(negedge clk); rp_set = NP'(1) << 5;
    @(negedge clk); rp_set = '0;
    @(negedge clk);
    bus_addr = 16'h0010; bus_wdata = 64'h0000_0021; bus_we = 1'b1; rp_set = NP'(1) << 5;
    @(negedge clk);
    bus_we = 1'b0; rp_set = '0;
    check("R8 clear wins over set", ent(5), 64'h7700_0000_0000_0021);
  endtask

  task automatic t_range;
    logic [63:0] r;
    logic [NP*64-1:0] snap;
    snap = route_o;
    setsel(32'h40);
    bwrite(16'h0010, 64'hffff_ffff, 4'd4);
    bread(16'h0010, r);  check("R9 past table reads 0", r, 64'h0);
    setsel(32'h41);
    bwrite(16'h0010, 64'hffff_ffff, 4'd4);
    setsel(32'h05);
    bwrite(16'h0010, 64'hffff_ffff, 4'd4);
    bread(16'h0010, r);  check("R9 gap select reads 0", r, 64'h0);
    check("R9 table unchanged", {63'h0, route_o == snap}, 64'h1);
  endtask

  task automatic t_svc;
    @(negedge clk); req_set = NP'(1) << 7;
    @(negedge clk); req_set = '0;
    setsel(32'h1e);
    bwrite(16'h0010, 64'h0000_0041, 4'd4);
    check("R10 svc pulse", 64'(svc_o), 64'h80);
    @(negedge clk);
    check("R10 svc one cycle", 64'(svc_o), 64'h0);
    setsel(32'h20);
    bwrite(16'h0010, 64'h0000_0042, 4'd4);
    check("R10 no latch no svc", 64'(svc_o), 64'h0);
    @(negedge clk); req_clr = NP'(1) << 7;
    @(negedge clk); req_clr = '0;
    setsel(32'h1f);
    bwrite(16'h0010, 64'h0, 4'd4);
    check("R10 cleared latch no svc", 64'(svc_o), 64'h0);
    @(negedge clk); req_set = NP'(1) << 7; req_clr = NP'(1) << 7;
    @(negedge clk); req_set = '0; req_clr = '0;
    bwrite(16'h0010, 64'h0, 4'd4);
    check("R10 set wins, hi write svc", 64'(svc_o), 64'h80);
  endtask

  task automatic t_unknown;
    logic [63:0] r;
    setsel(32'h16);
    bread(16'h0020, r);  check("R11 offset 0x20 reads 0", r, 64'h0);
    bread(16'h0004, r);  check("R11 offset 0x04 reads 0", r, 64'h0);
    bwrite(16'h0020, 64'h99, 4'd4);
    bwrite(16'h0014, 64'h99, 4'd4);
    bread(16'h0000, r);  check("R11 write ignored sel", r, 64'h16);
    check("R11 write ignored entry3", ent(3), 64'hc300_0000_0000_a0b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_select;
    t_size;
    t_version;
    t_id;
    t_entry;
    t_rpend;
    t_range;
    t_svc;
    t_unknown;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule